// File: doc/BRIEF.md
# Shadow-Mode Bus Slave Wrapper

This block puts a small single-cycle memory behind a classic pipelined bus slave port and adds a second transaction mode. In plain mode an access finishes in the cycle after it is accepted. It answers either with an acknowledge or, when the address lies outside the memory, with an error. In shadow mode the access is accepted but not carried out. The master first decides whether the access may go ahead.

The master selects shadow mode with a cycle-wide tag that it holds for the whole bus cycle. A shadowed access is captured into a holding buffer and the slave raises stall. For a read, the captured item is only the address. The slave keeps stall raised until the master drives one of two outcome tags. A "go" outcome performs the buffered access and answers in the next cycle, in the same way as a plain access. A "kill" outcome throws the buffer away with no answer on the bus. Dropping the cycle strobe while stalled also throws the buffer away. Memory contents therefore change only for accesses the master has committed to.

Top module: `shadow_bus_slave`

## Requirements
- R1: While reset is applied, `bus_ack`, `bus_err` and `bus_stall` are all low.
- R2: A plain access is one accepted with `bus_shadow` low, `bus_cyc`, `bus_stb` high and `bus_stall` low, at an address below DEPTH. It raises `bus_ack` in the following cycle. A read returns the word last written to that address on `bus_rdat` in that cycle, and a write updates the memory.
- R3: A plain access at an address of DEPTH or more raises `bus_err` in the following cycle, with no `bus_ack`, and a write there leaves every memory word unchanged.
- R4: A shadowed access is one accepted with `bus_shadow` high. From the next cycle it holds `bus_stall` high with no `bus_ack` or `bus_err`, for as long as `bus_cyc` stays high and neither `bus_go` nor `bus_kill` is seen.
- R5: A shadowed write does not reach memory before `bus_go`. When `bus_go` is seen while stalled, the next cycle has `bus_stall` low and `bus_ack` high for exactly one cycle. The write then takes effect.
- R6: A shadowed read that receives `bus_go` presents the stored word on `bus_rdat` in the `bus_ack` cycle.
- R7: `bus_kill` while stalled discards the buffered access. The next cycle has `bus_stall` low with no `bus_ack` or `bus_err`, and memory is unchanged.
- R8: `bus_cyc` falling while stalled behaves exactly like `bus_kill`.
- R9: When `bus_go` and `bus_kill` are both high in the same stalled cycle, kill wins.
- R10: A shadowed access at an address of DEPTH or more answers `bus_go` with a single-cycle `bus_err` and no `bus_ack`, and a write there changes nothing.
- R11: `bus_ack` and `bus_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Access request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | AW | Word address |
| bus_wdat | input | DW | Write data |
| bus_shadow | input | 1 | Cycle tag: accesses in this cycle are shadowed |
| bus_go | input | 1 | Outcome tag: commit the held access |
| bus_kill | input | 1 | Outcome tag: discard the held access |
| bus_rdat | output | DW | Read data, valid with `bus_ack` on reads |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access refused (address out of range) |
| bus_stall | output | 1 | Slave is holding a shadowed access |

## Verification
The bench targets several corner cases:
- A killed shadow write is followed by a plain read of the same word. A design that wrote on acceptance would return the discarded data.
- The cycle strobe is dropped with no outcome tag. A design that ignored this path would stay stalled, which the next transaction would expose.
- Go and kill arrive together. A design with the priority reversed would acknowledge.
- Shadowed and plain accesses beyond the memory are checked. A design that wrapped the address would acknowledge and overwrite a low word.
- Long stall windows are checked cycle by cycle, together with a check that the acknowledge pulse lasts exactly one cycle.

// File: rtl/shadow_bus_pkg.sv
package shadow_bus_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/shadow_mem.sv
module shadow_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  assign rd_data = store[rd_idx];
endmodule

// File: rtl/shadow_hold_buf.sv
module shadow_hold_buf #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_adr,
  input  logic [DW-1:0] ld_dat,
  output logic          q_we,
  output logic [AW-1:0] q_adr,
  output logic [DW-1:0] q_dat
);
  logic          we_d;
  logic [AW-1:0] adr_d;
  logic [DW-1:0] dat_d;

  always_comb begin
    we_d  = q_we;
    adr_d = q_adr;
    dat_d = q_dat;
    if (load) begin
      we_d  = ld_we;
      adr_d = ld_adr;
      dat_d = ld_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_we  <= 1'b0;
      q_adr <= '0;
      q_dat <= '0;
    end else begin
      q_we  <= we_d;
      q_adr <= adr_d;
      q_dat <= dat_d;
    end
  end
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic stb,
  input  logic shadow,
  input  logic go,
  input  logic kill,
  output logic stall,
  output logic load_hold,
  output logic plain_acc,
  output logic commit_acc
);
  hold_state_e state_q, state_d;
  logic accept;

  assign stall      = (state_q == HS_HOLD);
  assign accept     = cyc & stb & ~stall;
  assign load_hold  = accept & shadow;
  assign plain_acc  = accept & ~shadow;
  assign commit_acc = stall & cyc & go & ~kill;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (load_hold) state_d = HS_HOLD;
      HS_HOLD: if (!cyc || kill || go) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/shadow_bus_slave.sv
module shadow_bus_slave #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_adr,
  input  logic [DW-1:0] bus_wdat,
  input  logic          bus_shadow,
  input  logic          bus_go,
  input  logic          bus_kill,
  output logic [DW-1:0] bus_rdat,
  output logic          bus_ack,
  output logic          bus_err,
  output logic          bus_stall
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  logic          load_hold, plain_acc, commit_acc;
  logic          h_we;
  logic [AW-1:0] h_adr;
  logic [DW-1:0] h_dat;

  shadow_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cyc        (bus_cyc),
    .stb        (bus_stb),
    .shadow     (bus_shadow),
    .go         (bus_go),
    .kill       (bus_kill),
    .stall      (bus_stall),
    .load_hold  (load_hold),
    .plain_acc  (plain_acc),
    .commit_acc (commit_acc)
  );

  shadow_hold_buf #(.AW(AW), .DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load   (load_hold),
    .ld_we  (bus_we),
    .ld_adr (bus_adr),
    .ld_dat (bus_wdat),
    .q_we   (h_we),
    .q_adr  (h_adr),
    .q_dat  (h_dat)
  );

  // access mux: committed buffer or live bus
  logic          acc_vld, acc_we, acc_in;
  logic [AW-1:0] acc_adr;
  logic [DW-1:0] acc_dat, mem_rd;

  assign acc_vld = plain_acc | commit_acc;
  assign acc_we  = commit_acc ? h_we  : bus_we;
  assign acc_adr = commit_acc ? h_adr : bus_adr;
  assign acc_dat = commit_acc ? h_dat : bus_wdat;
  assign acc_in  = ({1'b0, acc_adr} < LIMIT);

  shadow_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (acc_vld & acc_we & acc_in),
    .wr_idx  (acc_adr[IW-1:0]),
    .wr_data (acc_dat),
    .rd_idx  (acc_adr[IW-1:0]),
    .rd_data (mem_rd)
  );

  // response registers
  logic          ack_d, err_d, rdat_en;
  logic [DW-1:0] rdat_d;

  assign ack_d   = acc_vld & acc_in;
  assign err_d   = acc_vld & ~acc_in;
  assign rdat_en = acc_vld & ~acc_we & acc_in;

  always_comb begin
    rdat_d = bus_rdat;
    if (rdat_en) rdat_d = mem_rd;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      bus_ack  <= 1'b0;
      bus_err  <= 1'b0;
      bus_rdat <= '0;
    end else begin
      bus_ack  <= ack_d;
      bus_err  <= err_d;
      bus_rdat <= rdat_d;
    end
  end
endmodule

// File: rtl/shadow_bus_chk.sv
module shadow_bus_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc,
  input logic stb,
  input logic shadow,
  input logic go,
  input logic kill,
  input logic ack,
  input logic err,
  input logic stall
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ack && !err && !stall));

  // R11
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err));

  // R2
  plain_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !shadow && !stall) |=> (ack || err));

  // R4
  shadow_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && shadow && !stall) |=> (stall && !ack && !err));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cyc && !go && !kill) |=> (stall && !ack && !err));

  // R5
  go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cyc && go && !kill) |=> ((ack || err) && !stall));

  // R7 R9
  kill_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cyc && kill) |=> (!ack && !err && !stall));

  // R8
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cyc) |=> (!ack && !err && !stall));
endmodule

bind shadow_bus_slave shadow_bus_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .cyc    (bus_cyc),
  .stb    (bus_stb),
  .shadow (bus_shadow),
  .go     (bus_go),
  .kill   (bus_kill),
  .ack    (bus_ack),
  .err    (bus_err),
  .stall  (bus_stall)
);

// File: tb/tb_shadow_bus_slave.sv
`timescale 1ns/1ps
module tb_shadow_bus_slave;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic          clk, rst_n;
  logic          bus_cyc, bus_stb, bus_we, bus_shadow, bus_go, bus_kill;
  logic [AW-1:0] bus_adr;
  logic [DW-1:0] bus_wdat, bus_rdat;
  logic          bus_ack, bus_err, bus_stall;

  shadow_bus_slave #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] model [DEPTH];

  function automatic bit in_range(input logic [AW-1:0] a);
    return int'(a) < DEPTH;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_bus();
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_shadow = 0;
    bus_go = 0; bus_kill = 0; bus_adr = '0; bus_wdat = '0;
  endtask

  // plain access, result sampled in the cycle after acceptance
  task automatic plain(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d; bus_shadow = 0;
    tick();
    idle_bus();
    if (in_range(a)) begin
      chk("R2", "ack", 32'(bus_ack), 32'd1);
      chk("R3", "err", 32'(bus_err), 32'd0);
      if (!we) chk("R2", "rdat", bus_rdat, model[a[3:0]]);
      else model[a[3:0]] = d;
    end else begin
      chk("R3", "err", 32'(bus_err), 32'd1);
      chk("R3", "ack", 32'(bus_ack), 32'd0);
    end
    chk("R11", "ack&err", 32'(bus_ack & bus_err), 32'd0);
  endtask

  // outcome: 0 go, 1 kill, 2 drop cyc, 3 go+kill
  task automatic shadow_acc(input logic we, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int hold, input int outc);
    bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d; bus_shadow = 1;
    tick();
    bus_stb = 0; bus_adr = '0; bus_wdat = '0; bus_we = 0;
    chk("R4", "stall", 32'(bus_stall), 32'd1);
    chk("R4", "ack|err", 32'(bus_ack | bus_err), 32'd0);
    for (int i = 0; i < hold; i++) begin
      tick();
      chk("R4", "stall held", 32'(bus_stall), 32'd1);
      chk("R4", "no ack", 32'(bus_ack | bus_err), 32'd0);
    end
    case (outc)
      0: bus_go = 1;
      1: bus_kill = 1;
      2: bus_cyc = 0;
      default: begin bus_go = 1; bus_kill = 1; end
    endcase
    tick();
    idle_bus();
    chk("R5", "stall low", 32'(bus_stall), 32'd0);
    if (outc == 0) begin
      if (in_range(a)) begin
        chk("R5", "ack", 32'(bus_ack), 32'd1);
        chk("R10", "err", 32'(bus_err), 32'd0);
        if (!we) chk("R6", "rdat", bus_rdat, model[a[3:0]]);
        else model[a[3:0]] = d;
      end else begin
        chk("R10", "err", 32'(bus_err), 32'd1);
        chk("R10", "ack", 32'(bus_ack), 32'd0);
      end
      tick();
      chk("R5", "one-cycle ack", 32'(bus_ack | bus_err), 32'd0);
    end else begin
      if (outc == 2) chk("R8", "drop silent", 32'(bus_ack | bus_err), 32'd0);
      else if (outc == 3) chk("R9", "kill wins", 32'(bus_ack | bus_err), 32'd0);
      else chk("R7", "kill silent", 32'(bus_ack | bus_err), 32'd0);
    end
  endtask

  // read back a word to confirm memory contents (R3/R5/R7/R10)
  task automatic verify(input logic [AW-1:0] a);
    plain(1'b0, a, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_bus();
    rst_n = 0;
    #1;
    chk("R1", "ack", 32'(bus_ack), 32'd0);
    chk("R1", "err", 32'(bus_err), 32'd0);
    chk("R1", "stall", 32'(bus_stall), 32'd0);
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // fill memory deterministically
    for (int i = 0; i < DEPTH; i++) plain(1'b1, AW'(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < DEPTH; i++) verify(AW'(i));

    // directed corners
    plain(1'b1, AW'(DEPTH), 32'hDEAD_BEEF);            // R3 out-of-range write
    for (int i = 0; i < DEPTH; i++) verify(AW'(i));
    shadow_acc(1'b1, 8'd3, 32'h1111_2222, 5, 1);       // R7 kill write
    verify(8'd3);
    shadow_acc(1'b1, 8'd4, 32'h3333_4444, 2, 2);       // R8 drop cyc
    verify(8'd4);
    shadow_acc(1'b1, 8'd5, 32'h5555_6666, 0, 3);       // R9 go+kill
    verify(8'd5);
    shadow_acc(1'b1, 8'd6, 32'h7777_8888, 7, 0);       // R5 commit
    verify(8'd6);
    shadow_acc(1'b0, 8'd6, '0, 1, 0);                  // R6 shadow read
    shadow_acc(1'b1, 8'd200, 32'hBAD0_BAD0, 1, 0);     // R10 out of range
    for (int i = 0; i < DEPTH; i++) verify(AW'(i));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int op;
      a  = AW'($urandom % (DEPTH + 4));
      d  = $urandom;
      op = int'($urandom % 4);
      case (op)
        0: plain(1'b1, a, d);
        1: plain(1'b0, a, d);
        default: begin
          shadow_acc(logic'($urandom % 2), a, d, int'($urandom % 6), int'($urandom % 4));
          if (in_range(a)) verify(a);
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule